// File: doc/BRIEF.md
# Serial Port Queue Control and Receive Interrupt Unit

This unit sits between the receive shift register of a serial port, the CPU and the transmitter. It holds two byte queues of 16 entries each. One queue takes bytes from the receiver and hands them to the CPU. The other takes bytes from the CPU and hands them to the transmitter. A write-only 8-bit configuration register controls both queues. It turns queue mode on or off, flushes either queue, picks how the two DMA ready outputs behave and picks the receive interrupt threshold.

When queue mode is off, each queue holds a single byte. When it is on, each queue holds up to 16 bytes. The unit reports a data-ready flag, and it reports one interrupt identification code for the most urgent receive condition. A line-status event outranks data availability. A line-status event is either a line error fed in from outside or a byte lost to a full receive queue. The CPU acknowledges line status with a clear pulse.

Control is built from two enumerated state machines. The mode machine has the states `MODE_HOLD` and `MODE_QUEUE`. A configuration write with bit 0 set while in `MODE_HOLD` takes the ENABLE transition. A write with bit 0 clear while in `MODE_QUEUE` takes the DISABLE transition. Every other write stays in the current state. The interrupt machine has the states `IRQ_IDLE`, `IRQ_DATA` and `IRQ_LINE`. It goes to `IRQ_LINE` from any state whenever line status is pending. When no line status is pending, it goes to `IRQ_DATA` when the receive count is at or above the threshold, and to `IRQ_IDLE` otherwise.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset both queue counts are 0, data_ready is 0, int_id is 4'h1 (none pending), queue mode is off, dma_mode1 is 0 and txrdy is 1.
- R2: In queue mode each queue accepts up to 16 bytes and returns them in arrival order. A push into a full queue is discarded.
- R3: With queue mode off each queue holds one byte. A second receive push while a byte is held is dropped, and the held byte is kept.
- R4: A configuration write whose bit 0 differs from the current mode flushes both queues at that write's clock edge.
- R5: A write with bits 0 and 1 set flushes only the receive queue.
- R6: A write with bits 0 and 2 set flushes only the transmit queue.
- R7: A write with bit 0 clear while the mode is already off changes nothing. A flush bit in that write does not empty the queues.
- R8: int_id reads 4'h4 while the receive count is at or above the threshold, and 4'h1 below it. Threshold code bits 7:6 select 00=1, 01=4, 10=8 or 11=14 bytes. Bits 5:4 are ignored. With the mode off the threshold is 1.
- R9: data_ready is 1 exactly while the receive queue holds at least one byte.
- R10: A pending line status (a line_err pulse or a dropped receive push) makes int_id 4'h6 whatever the count. An ls_clr pulse withdraws it.
- R11: dma_mode1 equals bit 3 of the last enabling write while queue mode is on, and 0 otherwise. In mode 0, rxrdy means the receive queue is non-empty and txrdy means the transmit queue is empty. In mode 1, rxrdy means the receive count is at or above the threshold and txrdy means the transmit queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fcr_wr | input | 1 | Configuration register write strobe |
| fcr_data | input | 8 | Configuration write data |
| rx_push | input | 1 | Receive shift register delivers a byte |
| rx_byte | input | 8 | Byte from receive shift register |
| rx_pop | input | 1 | CPU removes the oldest received byte |
| rx_head | output | 8 | Oldest received byte |
| rx_level | output | 5 | Receive queue count |
| data_ready | output | 1 | Receive queue not empty |
| tx_push | input | 1 | CPU writes a byte to send |
| tx_byte | input | 8 | Byte to send |
| tx_pop | input | 1 | Transmitter takes the oldest byte |
| tx_head | output | 8 | Oldest byte to send |
| tx_level | output | 5 | Transmit queue count |
| line_err | input | 1 | Receive line error event |
| ls_clr | input | 1 | Acknowledge line status |
| int_id | output | 4 | Interrupt identification code |
| rxrdy | output | 1 | Receive DMA ready |
| txrdy | output | 1 | Transmit DMA ready |
| dma_mode1 | output | 1 | DMA ready signalling in mode 1 |

## Verification
Counts, rx_head, tx_head, data_ready, rxrdy, txrdy and dma_mode1 settle at the clock edge that takes a push, a pop or a configuration write, so they are due one edge after the stimulus. int_id passes through one more register stage: a count change, a line_err pulse or an ls_clr pulse shows on int_id one edge later, two edges after the stimulus. The bench drives inputs at the falling edge and samples at the next falling edge. Before each int_id check it adds one idle cycle. It sweeps every threshold code across all receive counts from 0 to 16, going both up and down.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic [3:0] {
        IID_NONE = 4'h1,
        IID_RDA  = 4'h4,
        IID_RLS  = 4'h6
    } iid_e;

    typedef enum logic {
        MODE_HOLD  = 1'b0,
        MODE_QUEUE = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        IRQ_IDLE = 2'd0,
        IRQ_DATA = 2'd1,
        IRQ_LINE = 2'd2
    } irq_state_e;

    function automatic logic [4:0] trig_bytes(input logic [1:0] sel);
        case (sel)
            2'b00:   trig_bytes = 5'd1;
            2'b01:   trig_bytes = 5'd4;
            2'b10:   trig_bytes = 5'd8;
            default: trig_bytes = 5'd14;
        endcase
    endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             one_slot,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             dropped
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    rd_ptr;
    logic [PW-1:0]    wr_ptr;
    logic [CW-1:0]    cnt;
    logic             take;
    logic             give;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        step = (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        full    = one_slot ? (cnt != '0) : (cnt == CW'(DEPTH));
        take    = push & ~full & ~clr;
        give    = pop & (cnt != '0) & ~clr;
        dropped = push & full & ~clr;
        dout    = mem[rd_ptr];
        count   = cnt;
    end

    always_ff @(posedge clk) begin
        if (take) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (take) begin
                wr_ptr <= step(wr_ptr);
            end
            if (give) begin
                rd_ptr <= step(rd_ptr);
            end
            case ({take, give})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // R2: the count never passes the queue depth
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R3: a single-slot queue never holds more than one byte
    a_r3_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
        one_slot |-> cnt <= CW'(1));

    // R2: a push that is turned away leaves the count unchanged
    a_r2_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (dropped && !pop) |=> $stable(cnt));

endmodule

// File: rtl/fcr_ctrl.sv
module fcr_ctrl
    import uart_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       fifo_on,
    output logic       clr_rx,
    output logic       clr_tx,
    output logic       dma_sel,
    output logic [1:0] trig_sel
);

    mode_e      mode_q;
    mode_e      mode_d;
    logic       dma_q;
    logic [1:0] trig_q;
    logic       toggle;
    logic       cfg_wr;
    logic       unused_rsvd;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_HOLD;
        end else begin
            mode_q <= mode_d;
        end
    end

    // next state: ENABLE and DISABLE transitions
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_HOLD:  if (wr_en && wr_data[0])  mode_d = MODE_QUEUE;
            MODE_QUEUE: if (wr_en && !wr_data[0]) mode_d = MODE_HOLD;
            default:    mode_d = MODE_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_q  <= 1'b0;
            trig_q <= 2'b00;
        end else if (cfg_wr) begin
            dma_q  <= wr_data[3];
            trig_q <= wr_data[7:6];
        end
    end

    // outputs
    always_comb begin
        cfg_wr      = wr_en & wr_data[0];
        toggle      = wr_en & (wr_data[0] != (mode_q == MODE_QUEUE));
        clr_rx      = toggle | (cfg_wr & wr_data[1]);
        clr_tx      = toggle | (cfg_wr & wr_data[2]);
        fifo_on     = (mode_q == MODE_QUEUE);
        dma_sel     = fifo_on & dma_q;
        trig_sel    = trig_q;
        unused_rsvd = ^wr_data[5:4];
    end

    // R7: a write with bit 0 clear while off leaves the mode off
    a_r7_off_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HOLD && wr_en && !wr_data[0]) |=> mode_q == MODE_HOLD);

    // R11: mode-1 signalling is never reported while queue mode is off
    a_r11_dma_needs_queue: assert property (@(posedge clk) disable iff (!rst_n)
        dma_sel |-> mode_q == MODE_QUEUE);

endmodule

// File: rtl/rx_irq.sv
module rx_irq
    import uart_fifo_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] thresh,
    input  logic          line_err,
    input  logic          overrun,
    input  logic          ls_clr,
    output iid_e          int_id
);

    irq_state_e state_q;
    irq_state_e state_d;
    logic       line_pend;
    logic       at_level;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_pend <= 1'b0;
        end else if (line_err || overrun) begin
            line_pend <= 1'b1;
        end else if (ls_clr) begin
            line_pend <= 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        at_level = (count >= thresh);
        state_d  = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (line_pend)     state_d = IRQ_LINE;
                else if (at_level) state_d = IRQ_DATA;
            end
            IRQ_DATA: begin
                if (line_pend)      state_d = IRQ_LINE;
                else if (!at_level) state_d = IRQ_IDLE;
            end
            IRQ_LINE: begin
                if (!line_pend) state_d = at_level ? IRQ_DATA : IRQ_IDLE;
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            IRQ_DATA: int_id = IID_RDA;
            IRQ_LINE: int_id = IID_RLS;
            default:  int_id = IID_NONE;
        endcase
    end

    // R10: pending line status wins on the next cycle
    a_r10_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
        line_pend |=> int_id == IID_RLS);

    // R8: at or above the threshold, data available is reported
    a_r8_data_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_pend && count >= thresh) |=> int_id == IID_RDA);

    // R8: below the threshold nothing is reported
    a_r8_below_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_pend && count < thresh) |=> int_id == IID_NONE);

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fcr_wr,
    input  logic [7:0]    fcr_data,
    input  logic          rx_push,
    input  logic [7:0]    rx_byte,
    input  logic          rx_pop,
    output logic [7:0]    rx_head,
    output logic [CW-1:0] rx_level,
    output logic          data_ready,
    input  logic          tx_push,
    input  logic [7:0]    tx_byte,
    input  logic          tx_pop,
    output logic [7:0]    tx_head,
    output logic [CW-1:0] tx_level,
    input  logic          line_err,
    input  logic          ls_clr,
    output logic [3:0]    int_id,
    output logic          rxrdy,
    output logic          txrdy,
    output logic          dma_mode1
);

    logic          fifo_on;
    logic          clr_rx;
    logic          clr_tx;
    logic          dma_sel;
    logic [1:0]    trig_sel;
    logic [CW-1:0] rx_thresh;
    logic          rx_full;
    logic          rx_drop;
    logic          tx_full;
    logic          tx_drop;
    logic          unused_tx;
    iid_e          iid;

    fcr_ctrl u_fcr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fcr_wr),
        .wr_data  (fcr_data),
        .fifo_on  (fifo_on),
        .clr_rx   (clr_rx),
        .clr_tx   (clr_tx),
        .dma_sel  (dma_sel),
        .trig_sel (trig_sel)
    );

    byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_rx),
        .one_slot (~fifo_on),
        .push     (rx_push),
        .din      (rx_byte),
        .pop      (rx_pop),
        .dout     (rx_head),
        .count    (rx_level),
        .full     (rx_full),
        .dropped  (rx_drop)
    );

    byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_tx),
        .one_slot (~fifo_on),
        .push     (tx_push),
        .din      (tx_byte),
        .pop      (tx_pop),
        .dout     (tx_head),
        .count    (tx_level),
        .full     (tx_full),
        .dropped  (tx_drop)
    );

    rx_irq #(.CW(CW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (rx_level),
        .thresh   (rx_thresh),
        .line_err (line_err),
        .overrun  (rx_drop),
        .ls_clr   (ls_clr),
        .int_id   (iid)
    );

    always_comb begin
        rx_thresh  = fifo_on ? CW'(trig_bytes(trig_sel)) : CW'(1);
        data_ready = (rx_level != '0);
        rxrdy      = dma_sel ? (rx_level >= rx_thresh) : data_ready;
        txrdy      = dma_sel ? ~tx_full : (tx_level == '0);
        dma_mode1  = dma_sel;
        int_id     = iid;
        unused_tx  = tx_drop ^ rx_full;
    end

    // R4: a mode change empties both queues
    a_r4_mode_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_wr && (fcr_data[0] != fifo_on)) |=> (rx_level == '0 && tx_level == '0));

    // R5: receive flush empties the receive queue
    a_r5_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_wr && fcr_data[0] && fcr_data[1]) |=> rx_level == '0);

    // R6: transmit flush empties the transmit queue
    a_r6_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_wr && fcr_data[0] && fcr_data[2]) |=> tx_level == '0);

    // R9: data_ready only rises after a receive push
    a_r9_ready_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> $past(rx_push));

endmodule

// File: tb/test_uart_fifo_ctl.sv
module test_uart_fifo_ctl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fcr_wr = 1'b0;
    logic [7:0] fcr_data = 8'h00;
    logic       rx_push = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_head;
    logic [4:0] rx_level;
    logic       data_ready;
    logic       tx_push = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_head;
    logic [4:0] tx_level;
    logic       line_err = 1'b0;
    logic       ls_clr = 1'b0;
    logic [3:0] int_id;
    logic       rxrdy;
    logic       txrdy;
    logic       dma_mode1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    uart_fifo_ctl i_uart_fifo_ctl (
        .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr), .fcr_data(fcr_data),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_pop(rx_pop),
        .rx_head(rx_head), .rx_level(rx_level), .data_ready(data_ready),
        .tx_push(tx_push), .tx_byte(tx_byte), .tx_pop(tx_pop),
        .tx_head(tx_head), .tx_level(tx_level), .line_err(line_err),
        .ls_clr(ls_clr), .int_id(int_id), .rxrdy(rxrdy), .txrdy(txrdy),
        .dma_mode1(dma_mode1)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_fcr(input logic [7:0] v);
        fcr_wr = 1'b1; fcr_data = v;
        tick();
        fcr_wr = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] v);
        rx_push = 1'b1; rx_byte = v;
        tick();
        rx_push = 1'b0;
    endtask

    task automatic pop_rx();
        rx_pop = 1'b1;
        tick();
        rx_pop = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] v);
        tx_push = 1'b1; tx_byte = v;
        tick();
        tx_push = 1'b0;
    endtask

    task automatic pop_tx();
        tx_pop = 1'b1;
        tick();
        tx_pop = 1'b0;
    endtask

    task automatic ack_line();
        ls_clr = 1'b1;
        tick();
        ls_clr = 1'b0;
        tick();
    endtask

    function automatic int level_of(input int code);
        return (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 rx_level", int'(rx_level), 0);
        chk("R1 tx_level", int'(tx_level), 0);
        chk("R1 data_ready", int'(data_ready), 0);
        chk("R1 int_id", int'(int_id), 1);
        chk("R1 dma_mode1", int'(dma_mode1), 0);
        chk("R1 txrdy", int'(txrdy), 1);

        // R3 single-byte holding in mode off
        push_rx(8'hA5);
        chk("R3 rx_level", int'(rx_level), 1);
        chk("R9 data_ready set", int'(data_ready), 1);
        chk("R11 rxrdy mode0", int'(rxrdy), 1);
        tick();
        chk("R3 int_id one byte", int'(int_id), 4);
        push_rx(8'h5A);
        chk("R3 level stays 1", int'(rx_level), 1);
        chk("R3 held byte kept", int'(rx_head), 8'hA5);
        tick();
        chk("R10 overrun id", int'(int_id), 6);
        ack_line();
        chk("R10 ack", int'(int_id), 4);

        // R7 write with bit 0 clear while off
        push_tx(8'h11);
        wr_fcr(8'hC6);
        chk("R7 rx kept", int'(rx_level), 1);
        chk("R7 tx kept", int'(tx_level), 1);
        chk("R7 dma off", int'(dma_mode1), 0);
        tick();
        chk("R7 threshold still 1", int'(int_id), 4);

        // R4 enabling flushes both
        wr_fcr(8'h01);
        chk("R4 enable rx flush", int'(rx_level), 0);
        chk("R4 enable tx flush", int'(tx_level), 0);
        chk("R9 data_ready clear", int'(data_ready), 0);
        tick();
        chk("R8 empty id", int'(int_id), 1);

        // R8 / R2 sweep over every threshold code
        for (int t = 0; t < 4; t++) begin
            int lvl;
            lvl = level_of(t);
            wr_fcr(8'h33 | 8'(t << 6));
            chk("R5 flush before sweep", int'(rx_level), 0);
            tick();
            chk("R8 id at zero", int'(int_id), 1);
            for (int n = 1; n <= 16; n++) begin
                push_rx(8'(n));
                chk("R2 level up", int'(rx_level), n);
                tick();
                chk("R8 id rising", int'(int_id), (n >= lvl) ? 4 : 1);
            end
            push_rx(8'd99);
            chk("R2 full push dropped", int'(rx_level), 16);
            tick();
            chk("R10 overrun in queue mode", int'(int_id), 6);
            ack_line();
            chk("R10 ack in queue mode", int'(int_id), 4);
            for (int k = 1; k <= 16; k++) begin
                chk("R2 order", int'(rx_head), k);
                pop_rx();
                tick();
                chk("R8 id falling", int'(int_id), ((16 - k) >= lvl) ? 4 : 1);
            end
            chk("R9 empty after drain", int'(data_ready), 0);
        end

        // R11 DMA signalling, threshold 4
        wr_fcr(8'h4B);
        chk("R11 mode1 flag", int'(dma_mode1), 1);
        for (int n = 1; n <= 4; n++) begin
            push_rx(8'(n));
            chk("R11 rxrdy mode1", int'(rxrdy), (n >= 4) ? 1 : 0);
        end
        chk("R11 txrdy mode1 empty", int'(txrdy), 1);
        for (int n = 0; n < 16; n++) begin
            push_tx(8'(16 + n));
        end
        chk("R2 tx full", int'(tx_level), 16);
        chk("R11 txrdy mode1 full", int'(txrdy), 0);
        push_tx(8'hEE);
        chk("R2 tx drop", int'(tx_level), 16);
        chk("R2 tx order", int'(tx_head), 16);
        pop_tx();
        chk("R2 tx order next", int'(tx_head), 17);
        chk("R11 txrdy mode1 not full", int'(txrdy), 1);
        wr_fcr(8'h41);
        chk("R11 mode0 flag", int'(dma_mode1), 0);
        chk("R11 txrdy mode0 not empty", int'(txrdy), 0);
        chk("R11 rxrdy mode0", int'(rxrdy), 1);
        chk("R11 no flush rx", int'(rx_level), 4);
        chk("R11 no flush tx", int'(tx_level), 15);

        // R6 transmit-only flush
        wr_fcr(8'h45);
        chk("R6 tx flushed", int'(tx_level), 0);
        chk("R6 rx kept", int'(rx_level), 4);
        chk("R11 txrdy mode0 empty", int'(txrdy), 1);

        // R5 receive-only flush
        push_tx(8'h22);
        wr_fcr(8'h43);
        chk("R5 rx flushed", int'(rx_level), 0);
        chk("R5 tx kept", int'(tx_level), 1);

        // R10 external line error outranks data
        push_rx(8'h33);
        push_rx(8'h34);
        push_rx(8'h35);
        push_rx(8'h36);
        tick();
        chk("R8 data at 4", int'(int_id), 4);
        line_err = 1'b1;
        tick();
        line_err = 1'b0;
        tick();
        chk("R10 line error priority", int'(int_id), 6);
        ack_line();
        chk("R10 back to data", int'(int_id), 4);

        // R4 disabling flushes both
        wr_fcr(8'h00);
        chk("R4 disable rx flush", int'(rx_level), 0);
        chk("R4 disable tx flush", int'(tx_level), 0);
        chk("R11 dma off when disabled", int'(dma_mode1), 0);
        tick();
        chk("R8 none after disable", int'(int_id), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule